// File: doc/BRIEF.md
# Two-Frame Controlled Slip Buffer

This block is an elastic store that carries T1 or E1 PCM time-slot bytes from a system bus clock domain into a line transmit clock domain. Its storage holds two frames, one per half. Within each half, byte address N always holds time slot N. A frame is 24 slots in T1 mode and 32 slots in E1 mode.

Writes carry a start-of-frame marker on slot 0. The reader stays idle until the writer has completed its second frame. It then starts one frame behind the writer, which leaves the store about half full. The two clocks may drift apart. At each read frame boundary the reader compares its position with a synchronized half-frame count from the writer. If the writer has pulled too far ahead, the reader skips one whole frame. If the writer has fallen behind, the reader repeats the frame it just read. Each kind of slip sets its own sticky status bit.

A bypass mode sends the write-side bytes straight to the output through one register. Bypass is meant for use when both domains run from the same clock.

Top module: `slip_buf_2frame`

## Requirements
- R1: While reset is held and right after its release, rd_valid_o, rd_sof_o, rd_data_o, slip_del_o and slip_dup_o are all 0.
- R2: No output byte is valid until the writer has entered its third frame, counted from the first wr_sof_i write. The first frame delivered is the second frame written, and its first valid byte carries rd_sof_o.
- R3: Each output frame has 24 bytes when e1_mode_i=0 and 32 bytes when e1_mode_i=1. The byte at position k of the frame is the byte written at slot k, where slot 0 is the write flagged by wr_sof_i. rd_sof_o is high on position 0 only.
- R4: When write and read rates are equal, output frames follow the written frame order without gaps or repeats, and neither slip flag is set.
- R5: When writes outrun reads, the reader drops exactly one whole written frame per slip and sets slip_del_o.
- R6: When reads outrun writes, the reader outputs the last frame a second time per slip and sets slip_dup_o.
- R7: Slips happen only at a read frame boundary. All bytes of one output frame come from the same written frame.
- R8: slip_del_o and slip_dup_o stay high until slip_clr_i is high on a read clock edge with no new slip of that kind. They are then 0 on the next edge.
- R9: With bypass_i=1, each read clock edge copies wr_en_i, wr_sof_i and wr_data_i to rd_valid_o, rd_sof_o and rd_data_o (data only when wr_en_i=1). Bypass requires the two clocks to be the same clock.
- R10: Outside bypass and once the reader has started, rd_valid_o is high on the read clock edge after each rd_en_i, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | System bus (write) clock |
| rd_clk_i | input | 1 | Line transmit (read) clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| e1_mode_i | input | 1 | 0: 24-slot frames, 1: 32-slot frames; static after reset |
| bypass_i | input | 1 | Pass write-side bytes straight to the output |
| wr_en_i | input | 1 | Write one time-slot byte |
| wr_sof_i | input | 1 | Current write is slot 0 of a new frame |
| wr_data_i | input | DATA_W | Time-slot byte to write |
| rd_en_i | input | 1 | Read one time-slot byte |
| rd_valid_o | output | 1 | rd_data_o holds a new byte |
| rd_sof_o | output | 1 | Output byte is slot 0 of a frame |
| rd_data_o | output | DATA_W | Output time-slot byte |
| slip_clr_i | input | 1 | Clear both slip flags (read domain) |
| slip_del_o | output | 1 | Sticky: a frame was dropped |
| slip_dup_o | output | 1 | Sticky: a frame was repeated |

## Verification
The assertions assume that frames are well formed. Every frame starts with one wr_sof_i write, carries exactly one mode's worth of slots, and has no early marker. Under that assumption the write half-frame count steps by one and its Gray code changes one bit at a time. They also assume that the rate mismatch stays well under half a frame per frame, the mode is held still, and bypass runs only on a shared clock. The stimulus writes whole frames at a fixed enable spacing and reads at a fixed enable spacing of its own, with a spacing ratio of at most 5:4. It drives both domains from one clock and applies reset before each mode or rate change.

// File: rtl/slip_buf_pkg.sv
package slip_buf_pkg;
  localparam int HF_W = 3;  // half-frame count, mod 8

  typedef enum logic [1:0] {
    SLIP_NONE = 2'd0,
    SLIP_DUP  = 2'd1,
    SLIP_DEL  = 2'd2
  } slip_e;

  function automatic logic [HF_W-1:0] bin2gray(input logic [HF_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [HF_W-1:0] gray2bin(input logic [HF_W-1:0] g);
    logic [HF_W-1:0] b;
    b[HF_W-1] = g[HF_W-1];
    for (int i = HF_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/slip_wr_ctrl.sv
module slip_wr_ctrl
  import slip_buf_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sof_i,
  input  logic [SLOT_W-1:0] half_slot_i,
  output logic [SLOT_W:0]   addr_o,
  output logic [HF_W-1:0]   gray_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [HF_W-1:0]   hf_q;   // {frame[1:0], second_half}
  logic              half_sel;

  assign half_sel = sof_i ? ~hf_q[1] : hf_q[1];
  assign addr_o   = {half_sel, (sof_i ? '0 : slot_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      hf_q   <= '1;  // first marker lands in frame 0
      gray_o <= bin2gray('1);
    end else begin
      gray_o <= bin2gray(hf_q);
      if (en_i) begin
        if (sof_i) begin
          slot_q <= SLOT_W'(1);
          hf_q   <= {hf_q[HF_W-1:1] + 2'd1, 1'b0};
        end else begin
          if (slot_q == half_slot_i) hf_q[0] <= 1'b1;
          if (slot_q != '1) slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/slip_sync.sv
module slip_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= rst_val_i;
      q_o    <= rst_val_i;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/slip_rd_ctrl.sv
module slip_rd_ctrl
  import slip_buf_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  input  logic [HF_W-1:0]   wr_hf_i,
  output logic [SLOT_W:0]   addr_o,
  output logic              fire_o,
  output logic              first_o,
  output logic              wrap_o,
  output logic [1:0]        frame_o,
  output logic              primed_o,
  output slip_e             slip_o
);
  localparam logic [HF_W-1:0] PRIME_HF = HF_W'(4);  // writer entered frame 2

  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        frame_q, frame_nx;
  logic              primed_q;
  logic [HF_W-1:0]   lead;
  slip_e             kind;

  assign fire_o   = en_i & primed_q;
  assign wrap_o   = fire_o & (slot_q == last_slot_i);
  assign first_o  = (slot_q == '0);
  assign addr_o   = {frame_q[0], slot_q};
  assign frame_o  = frame_q;
  assign primed_o = primed_q;

  // writer lead over the next read frame start, in half frames
  always_comb begin
    lead = wr_hf_i - {frame_q + 2'd1, 1'b0};
    unique case (lead)
      3'd1, 3'd2: begin kind = SLIP_NONE; frame_nx = frame_q + 2'd1; end
      3'd3, 3'd4, 3'd5: begin kind = SLIP_DEL; frame_nx = frame_q + 2'd2; end
      default: begin kind = SLIP_DUP; frame_nx = frame_q; end
    endcase
  end

  assign slip_o = wrap_o ? kind : SLIP_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      frame_q  <= '0;
      primed_q <= 1'b0;
    end else if (!primed_q) begin
      if (wr_hf_i == PRIME_HF) begin
        primed_q <= 1'b1;
        frame_q  <= 2'd1;
        slot_q   <= '0;
      end
    end else if (fire_o) begin
      if (wrap_o) begin
        slot_q  <= '0;
        frame_q <= frame_nx;
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/slip_buf_2frame.sv
module slip_buf_2frame
  import slip_buf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOTS_T1 = 24,
  parameter int SLOTS_E1 = 32
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              e1_mode_i,
  input  logic              bypass_i,
  input  logic              wr_en_i,
  input  logic              wr_sof_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic              rd_sof_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              slip_clr_i,
  output logic              slip_del_o,
  output logic              slip_dup_o
);
  localparam int SLOT_W = $clog2(SLOTS_E1);
  localparam int DEPTH  = 2 * (1 << SLOT_W);

  logic [SLOT_W-1:0] last_slot, half_slot;
  logic [SLOT_W:0]   wr_addr, rd_addr;
  logic [HF_W-1:0]   wr_gray, rd_gray, rd_hf;
  logic              rd_fire, rd_first, rd_wrap, rd_primed;
  logic [1:0]        rd_frame;
  slip_e             rd_slip;
  logic [DATA_W-1:0] mem [DEPTH];

  assign last_slot = e1_mode_i ? SLOT_W'(SLOTS_E1 - 1) : SLOT_W'(SLOTS_T1 - 1);
  assign half_slot = e1_mode_i ? SLOT_W'(SLOTS_E1 / 2) : SLOT_W'(SLOTS_T1 / 2);

  slip_wr_ctrl #(.SLOT_W(SLOT_W)) i_wr (
    .clk_i      (wr_clk_i),
    .rst_ni     (rst_ni),
    .en_i       (wr_en_i),
    .sof_i      (wr_sof_i),
    .half_slot_i(half_slot),
    .addr_o     (wr_addr),
    .gray_o     (wr_gray)
  );

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wr_addr] <= wr_data_i;
  end

  slip_sync #(.W(HF_W)) i_sync (
    .clk_i    (rd_clk_i),
    .rst_ni   (rst_ni),
    .rst_val_i(bin2gray('1)),
    .d_i      (wr_gray),
    .q_o      (rd_gray)
  );

  assign rd_hf = gray2bin(rd_gray);

  slip_rd_ctrl #(.SLOT_W(SLOT_W)) i_rd (
    .clk_i      (rd_clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rd_en_i & ~bypass_i),
    .last_slot_i(last_slot),
    .wr_hf_i    (rd_hf),
    .addr_o     (rd_addr),
    .fire_o     (rd_fire),
    .first_o    (rd_first),
    .wrap_o     (rd_wrap),
    .frame_o    (rd_frame),
    .primed_o   (rd_primed),
    .slip_o     (rd_slip)
  );

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_sof_o   <= 1'b0;
      rd_data_o  <= '0;
    end else if (bypass_i) begin
      rd_valid_o <= wr_en_i;
      rd_sof_o   <= wr_en_i & wr_sof_i;
      if (wr_en_i) rd_data_o <= wr_data_i;
    end else begin
      rd_valid_o <= rd_fire;
      rd_sof_o   <= rd_fire & rd_first;
      if (rd_fire) rd_data_o <= mem[rd_addr];
    end
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slip_del_o <= 1'b0;
      slip_dup_o <= 1'b0;
    end else begin
      if (rd_slip == SLIP_DEL) slip_del_o <= 1'b1;
      else if (slip_clr_i)     slip_del_o <= 1'b0;
      if (rd_slip == SLIP_DUP) slip_dup_o <= 1'b1;
      else if (slip_clr_i)     slip_dup_o <= 1'b0;
    end
  end
endmodule

// File: rtl/slip_buf_2frame_chk.sv
module slip_buf_2frame_chk (
  input logic       wr_clk_i,
  input logic       rd_clk_i,
  input logic       rst_ni,
  input logic       bypass_i,
  input logic       rd_en_i,
  input logic       rd_valid_o,
  input logic       rd_sof_o,
  input logic       slip_clr_i,
  input logic       slip_del_o,
  input logic       slip_dup_o,
  input logic       rd_wrap,
  input logic       rd_primed,
  input logic [1:0] rd_frame,
  input logic [2:0] wr_gray
);
  a_r8_del_sticky: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    slip_del_o && !slip_clr_i |=> slip_del_o);

  a_r8_dup_sticky: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    slip_dup_o && !slip_clr_i |=> slip_dup_o);

  a_r5_del_at_wrap: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $rose(slip_del_o) |-> $past(rd_wrap));

  a_r6_dup_at_wrap: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $rose(slip_dup_o) |-> $past(rd_wrap));

  a_r7_frame_hold: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_primed && !rd_wrap |=> $stable(rd_frame));

  a_r10_valid_needs_en: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o && !$past(bypass_i) |-> $past(rd_en_i));

  a_r2_idle_until_primed: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o && !$past(bypass_i) |-> $past(rd_primed));

  a_r3_sof_is_valid: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_sof_o |-> rd_valid_o);

  // R4: crossing count must move one Gray bit per write clock
  a_r4_gray_single_step: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

bind slip_buf_2frame slip_buf_2frame_chk i_chk (
  .wr_clk_i  (wr_clk_i),
  .rd_clk_i  (rd_clk_i),
  .rst_ni    (rst_ni),
  .bypass_i  (bypass_i),
  .rd_en_i   (rd_en_i),
  .rd_valid_o(rd_valid_o),
  .rd_sof_o  (rd_sof_o),
  .slip_clr_i(slip_clr_i),
  .slip_del_o(slip_del_o),
  .slip_dup_o(slip_dup_o),
  .rd_wrap   (rd_wrap),
  .rd_primed (rd_primed),
  .rd_frame  (rd_frame),
  .wr_gray   (wr_gray)
);

// File: tb/test_slip_buf_2frame.sv
module test_slip_buf_2frame;
  typedef struct packed {
    logic       e1;
    logic [7:0] wr_per;
    logic [7:0] rd_per;
    logic       exp_dup;
    logic       exp_del;
  } scen_t;

  localparam int NSCEN = 6;
  localparam scen_t SCEN [NSCEN] = '{
    '{1'b0, 8'd4, 8'd4, 1'b0, 1'b0},  // R4 T1 equal
    '{1'b1, 8'd4, 8'd4, 1'b0, 1'b0},  // R4 E1 equal
    '{1'b0, 8'd4, 8'd5, 1'b0, 1'b1},  // R5 T1 writer fast
    '{1'b1, 8'd4, 8'd5, 1'b0, 1'b1},  // R5 E1 writer fast
    '{1'b0, 8'd5, 8'd4, 1'b1, 1'b0},  // R6 T1 reader fast
    '{1'b1, 8'd5, 8'd4, 1'b1, 1'b0}   // R6 E1 reader fast
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       e1_mode_i = 1'b0, bypass_i = 1'b0;
  logic       wr_en_i = 1'b0, wr_sof_i = 1'b0, rd_en_i = 1'b0, slip_clr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_valid_o, rd_sof_o, slip_del_o, slip_dup_o;
  logic [7:0] rd_data_o;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  slip_buf_2frame i_slip_buf_2frame (
    .wr_clk_i(clk), .rd_clk_i(clk), .rst_ni(rst_ni),
    .e1_mode_i(e1_mode_i), .bypass_i(bypass_i),
    .wr_en_i(wr_en_i), .wr_sof_i(wr_sof_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o), .rd_sof_o(rd_sof_o),
    .rd_data_o(rd_data_o), .slip_clr_i(slip_clr_i),
    .slip_del_o(slip_del_o), .slip_dup_o(slip_dup_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en_i = 0; wr_sof_i = 0; rd_en_i = 0; slip_clr_i = 0; bypass_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic run_scen(input int idx);
    scen_t s;
    int n, ws, fw, frames, pos, prev_tag, tag, step, dups, dels, wper, rper;
    bit prev_en;
    s = SCEN[idx];
    n = s.e1 ? 32 : 24;
    wper = int'(s.wr_per);
    rper = int'(s.rd_per);
    e1_mode_i = s.e1;
    do_reset();
    ws = 0; fw = 0; frames = 0; pos = 0; prev_tag = 0; dups = 0; dels = 0; prev_en = 0;
    for (int cyc = 0; cyc < 30000 && frames < 15; cyc++) begin
      @(negedge clk);
      // R10: valid exactly one edge after each read once started
      if (frames > 0 || rd_valid_o)
        chk(rd_valid_o == prev_en, "R10 valid follows rd_en", int'(rd_valid_o), int'(prev_en));
      if (rd_valid_o) begin
        tag = int'(rd_data_o[7:5]);
        if (rd_sof_o) begin
          if (frames == 0) begin
            chk(tag == 1, "R2 first frame is second written", tag, 1);
          end else begin
            chk(pos == n - 1, "R3 frame length", pos + 1, n);
            step = (tag - prev_tag) & 7;
            if (step == 0) dups++;
            else if (step == 2) dels++;
            else chk(step == 1, "R7 frame order step", step, 1);
          end
          prev_tag = tag;
          pos = 0;
          frames++;
        end else begin
          if (frames == 0) chk(1'b0, "R2 first valid byte carries sof", 0, 1);
          pos++;
          chk(tag == prev_tag, "R7 whole frame from one source", tag, prev_tag);
        end
        chk(int'(rd_data_o[4:0]) == pos, "R3 slot mapping", int'(rd_data_o[4:0]), pos);
      end
      wr_en_i = (cyc % wper == 0);
      wr_sof_i = wr_en_i && (ws == 0);
      wr_data_i = {fw[2:0], ws[4:0]};
      if (wr_en_i) begin
        ws++;
        if (ws == n) begin ws = 0; fw++; end
      end
      rd_en_i = (cyc % rper == 1);
      prev_en = rd_en_i;
    end
    wr_en_i = 0; wr_sof_i = 0; rd_en_i = 0;
    chk(frames >= 15, "R2 output frames delivered", frames, 15);
    if (!s.exp_dup && !s.exp_del)
      chk(dups == 0 && dels == 0, "R4 no slips at equal rates", dups + dels, 0);
    if (s.exp_del) chk(dels > 0 && dups == 0, "R5 frame dropped", dels, 1);
    if (s.exp_dup) chk(dups > 0 && dels == 0, "R6 frame repeated", dups, 1);
    chk(slip_del_o == s.exp_del, "R5 slip_del_o", int'(slip_del_o), int'(s.exp_del));
    chk(slip_dup_o == s.exp_dup, "R6 slip_dup_o", int'(slip_dup_o), int'(s.exp_dup));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, all requirements");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk({rd_valid_o, rd_sof_o, slip_del_o, slip_dup_o} == 4'b0, "R1 flags in reset",
        int'({rd_valid_o, rd_sof_o, slip_del_o, slip_dup_o}), 0);
    chk(rd_data_o == 8'h00, "R1 data in reset", int'(rd_data_o), 0);
    do_reset();
    chk({rd_valid_o, rd_sof_o, slip_del_o, slip_dup_o} == 4'b0, "R1 after release",
        int'({rd_valid_o, rd_sof_o, slip_del_o, slip_dup_o}), 0);

    // R2: reads before any write give nothing
    rd_en_i = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rd_valid_o) chk(1'b0, "R2 idle before writer", 1, 0);
    end
    chk(!rd_valid_o, "R2 still idle", int'(rd_valid_o), 0);
    rd_en_i = 0;

    for (int k = 0; k < NSCEN; k++) run_scen(k);

    // R8: flag from last scenario holds, then clears
    repeat (10) @(negedge clk);
    chk(slip_dup_o == 1'b1, "R8 dup flag sticky", int'(slip_dup_o), 1);
    slip_clr_i = 1;
    @(negedge clk);
    slip_clr_i = 0;
    chk(slip_dup_o == 1'b0, "R8 dup flag cleared", int'(slip_dup_o), 0);
    run_scen(2);
    slip_clr_i = 1;
    @(negedge clk);
    slip_clr_i = 0;
    chk(slip_del_o == 1'b0, "R8 del flag cleared", int'(slip_del_o), 0);

    // R9 bypass
    do_reset();
    bypass_i = 1;
    wr_en_i = 1; wr_sof_i = 1; wr_data_i = 8'hA5;
    @(negedge clk);
    chk(rd_valid_o && rd_sof_o && rd_data_o == 8'hA5, "R9 bypass first byte",
        int'(rd_data_o), 'hA5);
    wr_sof_i = 0; wr_data_i = 8'h3C;
    @(negedge clk);
    chk(rd_valid_o && !rd_sof_o && rd_data_o == 8'h3C, "R9 bypass second byte",
        int'(rd_data_o), 'h3C);
    wr_en_i = 0; wr_data_i = 8'hFF;
    @(negedge clk);
    chk(!rd_valid_o && rd_data_o == 8'h3C, "R9 bypass idle holds data",
        int'(rd_data_o), 'h3C);
    bypass_i = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule